// File: doc/BRIEF.md
# Queued-Sample Pulse-Width Modulator

This block is a single-channel pulse-width modulator driven from a small synchronous register bus. Software writes duty-cycle samples into a four-entry queue. The modulator consumes one queued sample at each period boundary, and it may repeat each sample for 1, 2, 4 or 8 periods before it takes the next one. A counter clock is picked from four sources and then divided by a programmable prescaler. The counter runs through the period value plus two ticks. The single output pin is high while the counter sits below the current sample, and it can be inverted or held low.

Status reporting covers the queue occupancy, a live queue-empty bit and three sticky event bits: period wrap, compare match and a write into a full queue. Software clears each event bit by writing a 1 to it. A self-clearing soft-reset bit in the control register puts the whole block back into its reset state one cycle after it is written.

The modulator core is a two-state machine. In CORE_IDLE the counter is parked at zero and the output is low. The START transition (CORE_IDLE to CORE_RUN, taken when the enable bit is set) loads the queue head, if there is one, into the current sample and clears the counter and the repeat count. CORE_RUN counts prescaled ticks and pops the queue on wraps. The STOP transition (CORE_RUN to CORE_IDLE) is taken when the enable bit clears or a soft reset occurs.

Top module: `pwm_fifo_gen`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x08 (empty, no entries, no events) and `pwm_out` is 0.
- R2: With divide 1 and the bus-clock source, one output period lasts P+2 clocks, where P is the period register (offset 0x10). In normal mode the output is high for the first min(S, P+2) clocks of each period, where S is the current sample. A sample of 0 gives a constant low and a sample above P+1 gives a constant high.
- R3: A period register value of 0xFFFF gives the same 65536-tick period as 0xFFFE.
- R4: Control bits [15:4] hold a prescale field F. Each counter tick takes F+1 selected source ticks.
- R5: Control bits [17:16] select the tick source. 0 stops the counter. 1 gives every clock. 2 gives the `hf_tick` input. 3 gives the `slow_tick` input.
- R6: Control bits [19:18] set the output mode. 0 is normal. 1 gives the complement of the normal waveform. 2 and 3 hold the output at 0.
- R7: While control bit 0 (enable) is clear, `pwm_out` is 0 whatever the mode field holds.
- R8: Writes to offset 0x0C queue up to 4 samples. Enabling loads the queue head. Each later sample is taken at a period wrap. When the queue is empty at a wrap, the last sample is kept.
- R9: Control bits [2:1] give how many consecutive periods each sample is used for: 0 gives 1, 1 gives 2, 2 gives 4 and 3 gives 8.
- R10: Writing control bit 3 sets a soft reset. It reads back as 1 for one cycle, then clears itself together with all control, queue, sample and status state.
- R11: Status bits [2:0] give the number of queued samples (0 to 4). Status bit 3 is 1 exactly when that number is 0.
- R12: Status bit 4 (period wrap) and status bit 5 (counter equals sample) are sticky. Writing 1 to a bit at status offset 0x04 clears it.
- R13: A sample write while 4 samples are queued is dropped and sets sticky status bit 6. That bit is cleared by writing 1 to it.
- R14: Reading offset 0x0C returns the current sample while enabled and 0 while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hf_tick | input | 1 | High-frequency tick enable, source 2 |
| slow_tick | input | 1 | Slow (32 kHz) tick enable, source 3 |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
A control write that sets enable lands on clock edge e. The START transition happens on edge e+1, so the counter reads 0 in the cycle after e+1. The bench therefore samples `pwm_out` on falling edges from there on, one full period per window, and compares every sample against the expected level. Consecutive windows stay aligned to the wraps, which makes the sample hand-over and repeat checks cycle exact. Register reads are combinational and are sampled 1 ns after the address is set. The soft-reset bit is observed in the single cycle between the write edge and the clearing edge. Free-running tick sources have no known phase, so for them only the number of high cycles over a whole period is checked.

// File: rtl/pwmq_pkg.sv
package pwmq_pkg;
    localparam int ADDR_W = 5;
    localparam int BUS_W  = 32;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT   = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SAMPLE = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_PERIOD = 5'h10;

    typedef enum logic {
        CORE_IDLE = 1'b0,
        CORE_RUN  = 1'b1
    } core_state_t;

    typedef enum logic [1:0] {
        SRC_OFF  = 2'd0,
        SRC_BUS  = 2'd1,
        SRC_HF   = 2'd2,
        SRC_SLOW = 2'd3
    } tick_src_t;

    typedef enum logic [1:0] {
        OUT_NORMAL = 2'd0,
        OUT_INVERT = 2'd1,
        OUT_LOW_A  = 2'd2,
        OUT_LOW_B  = 2'd3
    } out_mode_t;
endpackage

// File: rtl/pwmq_fifo.sv
module pwmq_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)
                level <= level + 1'b1;
            else if (do_pop && !do_push)
                level <= level - 1'b1;
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    mem[g] <= '0;
                else if (do_push && wr_ptr == PTR_W'(g))
                    mem[g] <= push_data;
            end
        end
    endgenerate

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(DEPTH)); // R11

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (level == LVL_W'(DEPTH))); // R13
endmodule

// File: rtl/pwmq_tick.sv
module pwmq_tick
    import pwmq_pkg::*;
#(
    parameter int PRESC_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [1:0]         src_sel,
    input  logic               hf_tick,
    input  logic               slow_tick,
    input  logic [PRESC_W-1:0] div_field,
    output logic               tick
);
    logic               src_pulse;
    logic [PRESC_W-1:0] pcnt;

    always_comb begin
        unique case (tick_src_t'(src_sel))
            SRC_OFF:  src_pulse = 1'b0;
            SRC_BUS:  src_pulse = 1'b1;
            SRC_HF:   src_pulse = hf_tick;
            SRC_SLOW: src_pulse = slow_tick;
        endcase
    end

    assign tick = run && src_pulse && (pcnt == div_field);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pcnt <= '0;
        else if (clr || !run)
            pcnt <= '0;
        else if (src_pulse)
            pcnt <= (pcnt >= div_field) ? '0 : pcnt + 1'b1;
    end

    AST_TICK_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (src_sel == 2'd0) |-> !tick); // R5
endmodule

// File: rtl/pwmq_core.sv
module pwmq_core
    import pwmq_pkg::*;
#(
    parameter int DATA_W = 16,
    localparam int CNT_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic              tick,
    input  logic [DATA_W-1:0] period,
    input  logic [1:0]        rep_code,
    input  logic              q_empty,
    input  logic [DATA_W-1:0] q_head,
    output logic              q_pop,
    output logic              running,
    output logic [DATA_W-1:0] cur_sample,
    output logic              raw_high,
    output logic              wrap_evt,
    output logic              match_evt
);
    localparam logic [DATA_W-1:0] P_MAX   = {DATA_W{1'b1}};
    localparam logic [DATA_W-1:0] P_ALIAS = P_MAX - 1'b1;

    core_state_t       state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [2:0]        rep_q;
    logic [2:0]        rep_last;
    logic [DATA_W-1:0] eff_p;
    logic [CNT_W-1:0]  cnt_last;
    logic              at_last, rep_done, start;

    assign eff_p    = (period == P_MAX) ? P_ALIAS : period;
    assign cnt_last = {1'b0, eff_p} + 1'b1;
    assign rep_last = 3'((4'd1 << rep_code) - 4'd1);
    assign at_last  = (cnt_q == cnt_last);
    assign rep_done = (rep_q >= rep_last);
    assign running  = (state_q == CORE_RUN);
    assign start    = (state_q == CORE_IDLE) && en;

    assign wrap_evt  = running && tick && at_last;
    assign match_evt = running && tick && (cnt_q == {1'b0, cur_sample});
    assign q_pop     = !q_empty && (start || (wrap_evt && rep_done));
    assign raw_high  = running && (cnt_q < {1'b0, cur_sample});

    // state register: START and STOP transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CORE_IDLE;
        else if (clr)
            state_q <= CORE_IDLE;
        else begin
            unique case (state_q)
                CORE_IDLE: if (en)  state_q <= CORE_RUN;
                CORE_RUN:  if (!en) state_q <= CORE_IDLE;
            endcase
        end
    end

    // counter, repeat count and current sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            rep_q      <= '0;
            cur_sample <= '0;
        end else if (clr) begin
            cnt_q      <= '0;
            rep_q      <= '0;
            cur_sample <= '0;
        end else begin
            unique case (state_q)
                CORE_IDLE: begin
                    cnt_q <= '0;
                    rep_q <= '0;
                    if (start && !q_empty)
                        cur_sample <= q_head;
                end
                CORE_RUN: begin
                    if (tick) begin
                        if (at_last) begin
                            cnt_q <= '0;
                            if (rep_done) begin
                                rep_q <= '0;
                                if (!q_empty)
                                    cur_sample <= q_head;
                            end else begin
                                rep_q <= rep_q + 1'b1;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= {1'b0, P_MAX}); // R2

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_evt |=> (cnt_q == '0)); // R2

    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !raw_high); // R7
endmodule

// File: rtl/pwm_fifo_gen.sv
module pwm_fifo_gen
    import pwmq_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 4,
    parameter int PRESC_W = 12,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hf_tick,
    input  logic              slow_tick,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              pwm_out
);
    logic               en_q, swr_q;
    logic [1:0]         rep_q, src_q, mode_q;
    logic [PRESC_W-1:0] presc_q;
    logic [DATA_W-1:0]  period_q;
    logic               flg_wrap, flg_match, flg_werr;

    logic wr_ctrl, wr_stat, wr_smp, wr_per;
    logic tick, q_pop, q_full, q_empty, running, raw_high, wrap_evt, match_evt;
    logic [DATA_W-1:0] q_head, cur_sample;
    logic [LVL_W-1:0]  q_level;
    logic              unused_bits;

    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == OFS_CTRL);
    assign wr_stat = bus_sel && bus_wr && (bus_addr == OFS_STAT);
    assign wr_smp  = bus_sel && bus_wr && (bus_addr == OFS_SAMPLE) && !swr_q;
    assign wr_per  = bus_sel && bus_wr && (bus_addr == OFS_PERIOD);
    assign unused_bits = ^{bus_wdata[BUS_W-1:20]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; swr_q <= 1'b0; rep_q <= '0;
            src_q <= '0; mode_q <= '0; presc_q <= '0; period_q <= '0;
        end else if (swr_q) begin
            en_q <= 1'b0; swr_q <= 1'b0; rep_q <= '0;
            src_q <= '0; mode_q <= '0; presc_q <= '0; period_q <= '0;
        end else begin
            if (wr_ctrl) begin
                if (bus_wdata[3]) begin
                    swr_q <= 1'b1;
                    en_q <= 1'b0; rep_q <= '0; src_q <= '0;
                    mode_q <= '0; presc_q <= '0;
                end else begin
                    en_q    <= bus_wdata[0];
                    rep_q   <= bus_wdata[2:1];
                    presc_q <= bus_wdata[4 +: PRESC_W];
                    src_q   <= bus_wdata[17:16];
                    mode_q  <= bus_wdata[19:18];
                end
            end
            if (wr_per)
                period_q <= bus_wdata[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flg_wrap <= 1'b0; flg_match <= 1'b0; flg_werr <= 1'b0;
        end else if (swr_q) begin
            flg_wrap <= 1'b0; flg_match <= 1'b0; flg_werr <= 1'b0;
        end else begin
            flg_wrap  <= wrap_evt  || (flg_wrap  && !(wr_stat && bus_wdata[4]));
            flg_match <= match_evt || (flg_match && !(wr_stat && bus_wdata[5]));
            flg_werr  <= (wr_smp && q_full) || (flg_werr && !(wr_stat && bus_wdata[6]));
        end
    end

    pwmq_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .clr(swr_q),
        .push(wr_smp), .push_data(bus_wdata[DATA_W-1:0]), .pop(q_pop),
        .head(q_head), .level(q_level), .full(q_full), .empty(q_empty)
    );

    pwmq_tick #(.PRESC_W(PRESC_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .clr(swr_q), .run(running),
        .src_sel(src_q), .hf_tick(hf_tick), .slow_tick(slow_tick),
        .div_field(presc_q), .tick(tick)
    );

    pwmq_core #(.DATA_W(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .clr(swr_q), .en(en_q), .tick(tick),
        .period(period_q), .rep_code(rep_q), .q_empty(q_empty), .q_head(q_head),
        .q_pop(q_pop), .running(running), .cur_sample(cur_sample),
        .raw_high(raw_high), .wrap_evt(wrap_evt), .match_evt(match_evt)
    );

    always_comb begin
        unique case (out_mode_t'(mode_q))
            OUT_NORMAL: pwm_out = en_q && raw_high;
            OUT_INVERT: pwm_out = en_q && running && !raw_high;
            OUT_LOW_A:  pwm_out = 1'b0;
            OUT_LOW_B:  pwm_out = 1'b0;
        endcase
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[0]            = en_q;
                bus_rdata[2:1]          = rep_q;
                bus_rdata[3]            = swr_q;
                bus_rdata[4 +: PRESC_W] = presc_q;
                bus_rdata[17:16]        = src_q;
                bus_rdata[19:18]        = mode_q;
            end
            OFS_STAT: begin
                bus_rdata[2:0] = 3'(q_level);
                bus_rdata[3]   = q_empty;
                bus_rdata[4]   = flg_wrap;
                bus_rdata[5]   = flg_match;
                bus_rdata[6]   = flg_werr;
            end
            OFS_SAMPLE: bus_rdata[DATA_W-1:0] = en_q ? cur_sample : '0;
            OFS_PERIOD: bus_rdata[DATA_W-1:0] = period_q;
            default:    bus_rdata = '0;
        endcase
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !pwm_out); // R7

    AST_SWR_SELF: assert property (@(posedge clk) disable iff (!rst_n)
        swr_q |=> (!swr_q && !en_q && q_empty)); // R10

    AST_MUTE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q[1] |-> !pwm_out); // R6
endmodule

// File: tb/tb_pwm_fifo_gen.sv
`timescale 1ns/1ps
module tb_pwm_fifo_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hf_tick = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    pwm_fifo_gen dut (
        .clk(clk), .rst_n(rst_n), .hf_tick(hf_tick), .slow_tick(slow_tick),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;
    always @(negedge clk) hf_tick <= ~hf_tick;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] mk_ctrl(bit en, int rep, int presc, int src, int mode);
        return (32'(mode) << 18) | (32'(src) << 16) | (32'(presc) << 4)
             | (32'(rep) << 1) | 32'(en);
    endfunction

    task automatic clean();
        wr(5'h00, 32'h8);
    endtask

    // samples one window of L cycles, expects high for the first H (inverted if inv)
    task automatic window(input int L, input int H, input bit inv, input string req);
        int bad = 0;
        int highs = 0;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
            if (pwm_out !== (((i < H) ? 1'b1 : 1'b0) ^ inv)) bad++;
        end
        chk(bad == 0, req, highs, inv ? (L - H) : H);
    endtask

    task automatic count_highs(input int L, output int highs);
        highs = 0;
        for (int i = 0; i < L; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(5'h00, d); chk(d == 0, "R1 ctrl", d, 0);
        rd(5'h04, d); chk(d == 32'h8, "R1 status", d, 8);
        chk(pwm_out == 1'b0, "R1 pwm_out", pwm_out, 0);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        clean();
        wr(5'h10, 6); wr(5'h0C, 3);
        rd(5'h04, d); chk(d[3:0] == 4'h1, "R11 level one", d[3:0], 1);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        window(8, 3, 0, "R2 first period");
        window(8, 3, 0, "R8 empty queue keeps sample");
        rd(5'h0C, d); chk(d == 3, "R14 sample while enabled", d, 3);
        wr(5'h00, 0);
        rd(5'h0C, d); chk(d == 0, "R14 sample while disabled", d, 0);
    endtask

    task automatic t_edges();
        clean();
        wr(5'h10, 2); wr(5'h0C, 0);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        window(4, 0, 0, "R2 zero sample");
        clean();
        wr(5'h10, 2); wr(5'h0C, 20);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        window(4, 4, 0, "R2 sample above period");
    endtask

    task automatic t_alias();
        clean();
        wr(5'h10, 32'hFFFF); wr(5'h0C, 1);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        window(65536, 1, 0, "R3 alias period body");
        window(2, 1, 0, "R3 alias period wrap");
    endtask

    task automatic t_presc();
        clean();
        wr(5'h10, 1); wr(5'h0C, 1);
        wr(5'h00, mk_ctrl(1, 0, 2, 1, 0));
        window(9, 3, 0, "R4 divide by three");
        window(9, 3, 0, "R4 second period");
    endtask

    task automatic t_src();
        int h;
        logic [31:0] d;
        clean();
        wr(5'h10, 2); wr(5'h0C, 1);
        wr(5'h00, mk_ctrl(1, 0, 0, 2, 0));
        count_highs(8, h);
        count_highs(8, h); chk(h == 2, "R5 hf source", h, 2);
        clean();
        wr(5'h10, 2); wr(5'h0C, 2);
        wr(5'h00, mk_ctrl(1, 0, 0, 0, 0));
        count_highs(10, h); chk(h == 10, "R5 source off frozen", h, 10);
        wr(5'h00, 0);
        rd(5'h04, d); chk(d[4] == 1'b0, "R5 no wrap when off", d[4], 0);
    endtask

    task automatic t_modes();
        int h;
        clean();
        wr(5'h10, 4); wr(5'h0C, 2);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 1));
        window(6, 2, 1, "R6 inverted");
        clean();
        wr(5'h10, 4); wr(5'h0C, 2);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 2));
        count_highs(12, h); chk(h == 0, "R6 mode two low", h, 0);
        clean();
        wr(5'h10, 2); wr(5'h0C, 2);
        wr(5'h00, mk_ctrl(0, 0, 0, 1, 1));
        count_highs(10, h); chk(h == 0, "R7 disabled inverted low", h, 0);
    endtask

    task automatic t_repeat();
        clean();
        wr(5'h10, 4); wr(5'h0C, 1); wr(5'h0C, 3);
        wr(5'h00, mk_ctrl(1, 1, 0, 1, 0));
        window(6, 1, 0, "R9 sample A period 1");
        window(6, 1, 0, "R9 sample A period 2");
        window(6, 3, 0, "R9 sample B period 1");
        window(6, 3, 0, "R9 sample B period 2");
        window(6, 3, 0, "R8 hold after empty");
    endtask

    task automatic t_full();
        logic [31:0] d;
        clean();
        wr(5'h10, 4);
        for (int k = 1; k <= 5; k++) wr(5'h0C, 32'(k));
        rd(5'h04, d); chk(d[6:0] == 7'h44, "R13 full drop status", d[6:0], 32'h44);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        window(6, 1, 0, "R8 queue entry 1");
        window(6, 2, 0, "R8 queue entry 2");
        window(6, 3, 0, "R8 queue entry 3");
        window(6, 4, 0, "R8 queue entry 4");
        window(6, 4, 0, "R13 fifth write dropped");
        wr(5'h00, 0);
        wr(5'h04, 32'h40);
        rd(5'h04, d); chk(d[6] == 1'b0, "R13 error cleared", d[6], 0);
    endtask

    task automatic t_flags();
        logic [31:0] d;
        clean();
        wr(5'h10, 2); wr(5'h0C, 1);
        wr(5'h00, mk_ctrl(1, 0, 0, 1, 0));
        repeat (10) @(negedge clk);
        wr(5'h00, 0);
        repeat (3) @(negedge clk);
        rd(5'h04, d); chk(d[6:0] == 7'h38, "R12 sticky flags", d[6:0], 32'h38);
        wr(5'h04, 32'h30);
        rd(5'h04, d); chk(d[6:0] == 7'h08, "R12 write one clears", d[6:0], 8);
    endtask

    task automatic t_swr();
        logic [31:0] d;
        clean();
        wr(5'h0C, 5); wr(5'h0C, 6);
        wr(5'h00, mk_ctrl(0, 3, 5, 2, 1));
        wr(5'h00, 32'h8);
        bus_addr = 5'h00;
        #1 chk(bus_rdata[3] == 1'b1, "R10 reset bit visible", bus_rdata[3], 1);
        rd(5'h00, d); chk(d == 0, "R10 self clear", d, 0);
        rd(5'h04, d); chk(d == 32'h8, "R10 queue flushed", d, 8);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_edges();
        t_presc();
        t_src();
        t_modes();
        t_repeat();
        t_full();
        t_flags();
        t_swr();
        t_alias();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule